// File: doc/BRIEF.md
# Legacy System Control Port

This block is an 8-bit system control register for a PC-style platform, reached over a simple byte-wide I/O bus with separate read and write strobes. The control register holds a gate bit that enables the A20 address line and a bit that, when written as one, asks the platform for a system reset. The register reads back whatever was last written, so software can change the gate without disturbing the other bits.

Two write-only ports sit beside it. One clears a latched floating-point error interrupt; the latch is set by a rising edge on an external error input. The other is the power-on self-test progress port. Any value written there is accepted and discarded. The CPU, the address masking logic and the reset controller are outside the block. They take the A20 level, the one-cycle reset request pulse and the interrupt level from its outputs.

Top module: `sys_ctl_port`

## Requirements
- R1: After the asynchronous power-up reset (rst_ni low), a20_o, sys_rst_req_o and ferr_irq_o are 0, and a read of the control register at address 0x92 returns 0x00.
- R2: A write to address 0x92 stores the full byte. A read of 0x92 returns the stored byte on io_rdata_o, with io_rvalid_o high, in the cycle after the read strobe.
- R3: a20_o equals bit 1 of the stored control register and takes its new value in the cycle after the write.
- R4: A write to 0x92 with bit 0 set drives sys_rst_req_o high for exactly one cycle, the cycle after the write. A write with bit 0 clear gives no pulse.
- R5: While dev_rst_i is high, bit 0 of the control register is cleared and all other bits, including the A20 gate, keep their value. A write presented in the same cycle is ignored and gives no reset pulse.
- R6: A rising edge on ferr_i sets ferr_irq_o in the cycle after the edge is sampled. ferr_irq_o then stays set, and a level held high does not set it again once it has been cleared.
- R7: Any write to address 0xF0 clears ferr_irq_o, whatever the data. A rising edge on ferr_i in the same cycle wins, and the interrupt stays set.
- R8: A write to address 0x80 changes neither the outputs nor the control register.
- R9: A read of 0xF0 or of 0x80 returns 0xFF with io_rvalid_o high in the cycle after the read strobe.
- R10: A write to any other address is ignored. A read of any other address leaves io_rvalid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| dev_rst_i | input | 1 | Synchronous device reset; clears only the reset bit |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_wr_i | input | 1 | Write strobe, one cycle per access |
| io_rd_i | input | 1 | Read strobe, one cycle per access |
| io_rdata_o | output | 8 | Read data, valid with io_rvalid_o |
| io_rvalid_o | output | 1 | Read response for a decoded address |
| ferr_i | input | 1 | Floating-point error input, synchronous |
| a20_o | output | 1 | A20 gate enable level |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| ferr_irq_o | output | 1 | Latched floating-point error interrupt |

## Verification
The control register is written with patterns that set the gate alone, the reset bit alone, both bits, and every bit. This separates a gate that follows the wrong bit, a pulse that follows the stored level, and a read path that drops bits. A device reset that coincides with a write shows whether only bit 0 is cleared and whether the write is blocked. The error latch is tried with a fresh edge, with a held level after a clear, and with an edge in the same cycle as a clear, which gives the set-versus-clear priority. Writes to the progress port, to the clear port and to an unmapped neighbour address, made with the other state set, show which side effects each address may have.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
  parameter int unsigned IO_ADDR_W = 16;
  parameter int unsigned IO_DATA_W = 8;
  parameter logic [IO_ADDR_W-1:0] CTL_ADDR      = 16'h0092;
  parameter logic [IO_ADDR_W-1:0] FERR_CLR_ADDR = 16'h00F0;
  parameter logic [IO_ADDR_W-1:0] POST_ADDR     = 16'h0080;
  parameter int unsigned RST_BIT = 0;
  parameter int unsigned A20_BIT = 1;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTL  = 2'd1,
    TGT_FERR = 2'd2,
    TGT_POST = 2'd3
  } io_tgt_e;
endpackage

// File: rtl/sys_ctl_decode.sv
module sys_ctl_decode
  import sys_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = IO_ADDR_W,
  parameter logic [ADDR_W-1:0] CTL_A  = CTL_ADDR,
  parameter logic [ADDR_W-1:0] FERR_A = FERR_CLR_ADDR,
  parameter logic [ADDR_W-1:0] POST_A = POST_ADDR
) (
  input  logic [ADDR_W-1:0] addr_i,
  output io_tgt_e           tgt_o
);
  always_comb begin
    unique case (addr_i)
      CTL_A:   tgt_o = TGT_CTL;
      FERR_A:  tgt_o = TGT_FERR;
      POST_A:  tgt_o = TGT_POST;
      default: tgt_o = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/sys_ctl_reg.sv
module sys_ctl_reg
  import sys_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = IO_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic              rst_pulse_o
);
  logic [DATA_W-1:0] ctl_q;
  logic              pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (dev_rst_i) begin
        // device reset drops only the reset bit; a concurrent write is lost
        ctl_q[RST_BIT] <= 1'b0;
      end else if (wr_en_i) begin
        ctl_q   <= wdata_i;
        pulse_q <= wdata_i[RST_BIT];
      end
    end
  end

  assign ctl_o       = ctl_q;
  assign rst_pulse_o = pulse_q;
endmodule

// File: rtl/sys_ctl_ferr.sv
module sys_ctl_ferr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ferr_i,
  input  logic clr_i,
  output logic irq_o
);
  logic ferr_d_q;
  logic irq_q;
  logic rise;

  assign rise = ferr_i & ~ferr_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ferr_d_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      ferr_d_q <= ferr_i;
      // a new edge outranks a clear so no error is lost
      if (rise)       irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port
  import sys_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = IO_ADDR_W,
  parameter int unsigned DATA_W = IO_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              io_rvalid_o,
  input  logic              ferr_i,
  output logic              a20_o,
  output logic              sys_rst_req_o,
  output logic              ferr_irq_o
);
  localparam logic [DATA_W-1:0] WO_READ_VAL = {DATA_W{1'b1}};

  io_tgt_e           tgt;
  logic [DATA_W-1:0] ctl;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  sys_ctl_decode #(
    .ADDR_W (ADDR_W),
    .CTL_A  (ADDR_W'(CTL_ADDR)),
    .FERR_A (ADDR_W'(FERR_CLR_ADDR)),
    .POST_A (ADDR_W'(POST_ADDR))
  ) u_dec (
    .addr_i (io_addr_i),
    .tgt_o  (tgt)
  );

  sys_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_rst_i   (dev_rst_i),
    .wr_en_i     (io_wr_i && tgt == TGT_CTL),
    .wdata_i     (io_wdata_i),
    .ctl_o       (ctl),
    .rst_pulse_o (sys_rst_req_o)
  );

  sys_ctl_ferr u_ferr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ferr_i (ferr_i),
    .clr_i  (io_wr_i && tgt == TGT_FERR),
    .irq_o  (ferr_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      if (io_rd_i) begin
        unique case (tgt)
          TGT_CTL: begin
            rvalid_q <= 1'b1;
            rdata_q  <= ctl;
          end
          TGT_FERR, TGT_POST: begin
            rvalid_q <= 1'b1;
            rdata_q  <= WO_READ_VAL;
          end
          default: ;
        endcase
      end
    end
  end

  assign io_rdata_o  = rdata_q;
  assign io_rvalid_o = rvalid_q;
  assign a20_o       = ctl[A20_BIT];
endmodule

// File: rtl/sys_ctl_port_chk.sv
module sys_ctl_port_chk
  import sys_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = IO_ADDR_W,
  parameter int unsigned DATA_W = IO_DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dev_rst_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [DATA_W-1:0] io_wdata_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic              io_rvalid_o,
  input logic              ferr_i,
  input logic              a20_o,
  input logic              sys_rst_req_o,
  input logic              ferr_irq_o
);
  logic ctl_wr, ferr_clr, unmapped;
  assign ctl_wr   = io_wr_i && io_addr_i == ADDR_W'(CTL_ADDR) && !dev_rst_i;
  assign ferr_clr = io_wr_i && io_addr_i == ADDR_W'(FERR_CLR_ADDR);
  assign unmapped = io_addr_i != ADDR_W'(CTL_ADDR) && io_addr_i != ADDR_W'(FERR_CLR_ADDR)
                    && io_addr_i != ADDR_W'(POST_ADDR);

  a_r3_a20_follows_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> a20_o == $past(io_wdata_i[A20_BIT]));

  a_r4_pulse_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && io_wdata_i[RST_BIT]) |=> sys_rst_req_o);

  a_r4_pulse_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ctl_wr && io_wdata_i[RST_BIT])) |=> !sys_rst_req_o);

  a_r5_devrst_keeps_a20: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |=> $stable(a20_o));

  a_r7_clear_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_clr && !ferr_i) |=> !ferr_irq_o);

  a_r6_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_irq_o && !ferr_clr) |=> ferr_irq_o);

  a_r10_no_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && unmapped) |=> !io_rvalid_o);

  a_r9_wo_read_answers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !unmapped) |=> io_rvalid_o);
endmodule

bind sys_ctl_port sys_ctl_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dev_rst_i     (dev_rst_i),
  .io_addr_i     (io_addr_i),
  .io_wdata_i    (io_wdata_i),
  .io_wr_i       (io_wr_i),
  .io_rd_i       (io_rd_i),
  .io_rvalid_o   (io_rvalid_o),
  .ferr_i        (ferr_i),
  .a20_o         (a20_o),
  .sys_rst_req_o (sys_rst_req_o),
  .ferr_irq_o    (ferr_irq_o)
);

// File: tb/tb_sys_ctl_port.sv
module tb_sys_ctl_port;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_rst = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        ferr = 1'b0;
  logic        a20, rst_req, irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] data; string req; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_ctl_port dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_rst_i(dev_rst),
    .io_addr_i(addr), .io_wdata_i(wdata), .io_wr_i(wr), .io_rd_i(rd),
    .io_rdata_o(rdata), .io_rvalid_o(rvalid), .ferr_i(ferr),
    .a20_o(a20), .sys_rst_req_o(rst_req), .ferr_irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // monitor: every read response is popped against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected response", rdata, 8'h00);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rdata === e.data, e.req, rdata, e.data);
      end
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [7:0] e, input string req);
    exp_t x;
    @(negedge clk);
    addr = a; rd = 1'b1;
    x.data = e; x.req = req;
    exp_q.push_back(x);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      check(1'b0, "watchdog", 8'h00, 8'h01);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    check({a20, rst_req, irq} == 3'b000, "R1 outputs in reset", {5'b0, a20, rst_req, irq}, 8'h00);
    rst_n = 1'b1;
    idle(1);
    io_read(16'h0092, 8'h00, "R1 register after power-up");
    check(rvalid === 1'b1, "R2 rvalid on ctl read", {7'b0, rvalid}, 8'h01);

    // gate only
    io_write(16'h0092, 8'h02);
    check(a20 === 1'b1, "R3 a20 set", {7'b0, a20}, 8'h01);
    check(rst_req === 1'b0, "R4 no pulse for bit0 clear", {7'b0, rst_req}, 8'h00);
    io_read(16'h0092, 8'h02, "R2 readback 0x02");

    // reset bit alone
    io_write(16'h0092, 8'h01);
    check(rst_req === 1'b1, "R4 pulse after write", {7'b0, rst_req}, 8'h01);
    check(a20 === 1'b0, "R3 a20 cleared", {7'b0, a20}, 8'h00);
    idle(1);
    check(rst_req === 1'b0, "R4 pulse is one cycle", {7'b0, rst_req}, 8'h00);
    io_read(16'h0092, 8'h01, "R2 readback keeps bit0");

    // all bits
    io_write(16'h0092, 8'hFF);
    io_read(16'h0092, 8'hFF, "R2 readback 0xFF");

    // device reset with a concurrent write
    io_write(16'h0092, 8'hA7);
    @(negedge clk);
    dev_rst = 1'b1; addr = 16'h0092; wdata = 8'h00; wr = 1'b1;
    @(negedge clk);
    dev_rst = 1'b0; wr = 1'b0;
    check(rst_req === 1'b0, "R5 no pulse during device reset", {7'b0, rst_req}, 8'h00);
    check(a20 === 1'b1, "R5 a20 kept", {7'b0, a20}, 8'h01);
    io_read(16'h0092, 8'hA6, "R5 only bit0 cleared");

    // error latch
    ferr = 1'b1;
    idle(1);
    check(irq === 1'b1, "R6 edge sets irq", {7'b0, irq}, 8'h01);
    io_write(16'h0080, 8'hFF);
    check(irq === 1'b1 && a20 === 1'b1 && rst_req === 1'b0, "R8 post write no effect",
          {5'b0, irq, a20, rst_req}, 8'h06);
    io_read(16'h0092, 8'hA6, "R8 register unchanged by post write");
    io_write(16'h00F0, 8'h5A);
    check(irq === 1'b0, "R7 clear write", {7'b0, irq}, 8'h00);
    idle(3);
    check(irq === 1'b0, "R6 held level does not re-set", {7'b0, irq}, 8'h00);
    ferr = 1'b0;
    idle(1);
    @(negedge clk);
    ferr = 1'b1; addr = 16'h00F0; wdata = 8'h00; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    check(irq === 1'b1, "R7 edge wins over clear", {7'b0, irq}, 8'h01);
    ferr = 1'b0;

    io_read(16'h00F0, 8'hFF, "R9 read of clear port");
    io_read(16'h0080, 8'hFF, "R9 read of post port");

    // unmapped
    io_write(16'h0093, 8'h01);
    check(rst_req === 1'b0 && a20 === 1'b1 && irq === 1'b1, "R10 unmapped write ignored",
          {5'b0, irq, a20, rst_req}, 8'h06);
    io_read(16'h0092, 8'hA6, "R10 register unchanged");
    @(negedge clk);
    addr = 16'h0192; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(rvalid === 1'b0, "R10 no read response", {7'b0, rvalid}, 8'h00);

    idle(3);
    check(exp_q.size() == 0, "R2 all reads answered", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule